// File: doc/BRIEF.md
# Serial Peripheral Controller with Conflict and Collision Flags

This core moves one byte at a time over a four-wire synchronous serial link and sits behind a small single-cycle register bus. In master mode it generates the serial clock from a programmable 16-bit divisor. It shifts the outgoing byte out most significant bit first and samples the returned byte on each rising clock edge. In slave mode it follows an external clock while its select input is held low.

Two fault conditions are tracked. If another device pulls the select input low while this core is an enabled master, the core raises a conflict flag and aborts the transfer. It then clears its own enable and master bits, so it falls back to being a disabled slave. If software writes the data register while a byte is still moving, a collision flag is raised and the written byte is thrown away. The flags are cleared only by reading the status register. The interrupt line combines the completion and conflict flags under an enable bit.

Top module: `spi_ctrl_core`

## Requirements
- R1: After reset the control, status, divisor and data registers read 0x00, and `sck_o` and `irq` are low.
- R2: The divisor is {address 4, address 3}. A clock pulse is produced every max(divisor,1) system cycles while a master transfer runs. `sck_o` toggles on each pulse, so its period is twice the divisor.
- R3: A master transfer starts with a data-register (address 2) write while control bit 5 (enable) and bit 4 (master) are 1. `sck_o` idles low and rises 8 times. `mosi_o` carries the byte MSB first and changes only on falling edges. `miso_i` is sampled on rising edges, and the received byte reads back at address 2.
- R4: Status bit 7 (complete) is set when the eighth bit has been shifted.
- R5: A data-register write during an active transfer sets status bit 5 (collision). The written byte is discarded and the transfer finishes with its original byte.
- R6: While enable and master are both 1, a low `ss_n_i` sets status bit 4 (conflict). It clears control bits 5 and 4 and aborts the transfer with `sck_o` low. Hardware never sets those control bits again.
- R7: `irq` is high while control bit 7 is 1 and status bit 7 or bit 4 is 1.
- R8: A status read (address 1) returns the current flags and clears them. A flag-setting event in the same cycle as the read leaves that flag set.
- R9: In slave mode (enable 1, master 0), with `ss_n_i` low, `mosi_i` is shifted in on rising `sck_i` edges. `miso_o` presents the byte last written to address 2, MSB first, and changes after falling edges. Status bit 7 is set after eight rising edges.
- R10: Control (address 0) and divisor registers read back the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| mosi_i | input | 1 | Serial data in (slave) |
| mosi_o | output | 1 | Serial data out (master) |
| miso_i | input | 1 | Serial data in (master) |
| miso_o | output | 1 | Serial data out (slave) |
| ss_n_i | input | 1 | Active-low select / conflict detect |

## Verification
A master byte with divisor D ends 16·D cycles after the data write: the first rise comes D cycles after the write and later rises follow every 2·D cycles. The bench waits 16·D+4 cycles before reading status, and it times the rises with a cycle counter. Conflict and collision flags and the control-bit clearing appear one edge after the causing cycle, so they are read at the next bus access. Slave edges pass a two-stage synchronizer, so `miso_o` is sampled four cycles after each falling `sck_i`. Status clearing is checked by a second read right after the first.

// File: rtl/spi_ctrl_core.sv
module spi_ctrl_core #(
  parameter int AW = 3,
  parameter int DIV_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          irq,
  input  logic          sck_i,
  output logic          sck_o,
  input  logic          mosi_i,
  output logic          mosi_o,
  input  logic          miso_i,
  output logic          miso_o,
  input  logic          ss_n_i
);
  localparam logic [AW-1:0] A_CTRL = AW'(0), A_STAT = AW'(1), A_DATA = AW'(2),
                            A_DIVL = AW'(3), A_DIVH = AW'(4);

  logic [7:0] ctrl_q, div_lo_q, div_hi_q, tx_sh, rx_sh, rx_data;
  logic [DIV_W-1:0] brg_q;
  logic [2:0] bit_q, sck_sync;
  logic busy_q, sck_q, done_q, wcol_q, modf_q;

  wire wr      = bus_sel & bus_wr;
  wire rd_stat = bus_sel & ~bus_wr & (bus_addr == A_STAT);
  wire en      = ctrl_q[5];
  wire mst     = ctrl_q[4];
  wire fault   = en & mst & ~ss_n_i;
  wire active  = busy_q | (bit_q != 3'd0);
  wire data_wr = wr & (bus_addr == A_DATA);
  wire collide = data_wr & en & active;
  wire start   = data_wr & en & mst & ~active & ~fault;
  wire slv_ld  = data_wr & en & ~mst & ~active;
  wire [DIV_W-1:0] divisor = DIV_W'({div_hi_q, div_lo_q});
  wire tick    = busy_q & (brg_q <= DIV_W'(1));
  wire slv     = en & ~mst & ~ss_n_i;
  wire s_rise  = slv & sck_sync[1] & ~sck_sync[2];
  wire s_fall  = slv & ~sck_sync[1] & sck_sync[2];
  wire done_set = (tick & sck_q & (bit_q == 3'd7)) | (s_rise & (bit_q == 3'd7));

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_q;
      A_STAT:  bus_rdata = {done_q, 1'b0, wcol_q, modf_q, 4'b0};
      A_DATA:  bus_rdata = rx_data;
      A_DIVL:  bus_rdata = div_lo_q;
      A_DIVH:  bus_rdata = div_hi_q;
      default: bus_rdata = 8'h00;
    endcase
  end

  assign irq    = ctrl_q[7] & (done_q | modf_q);
  assign sck_o  = sck_q;
  assign mosi_o = en & mst & tx_sh[7];
  assign miso_o = slv & tx_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; div_lo_q <= '0; div_hi_q <= '0;
      done_q <= 1'b0; wcol_q <= 1'b0; modf_q <= 1'b0;
      sck_sync <= '0; brg_q <= '0;
    end else begin
      if (wr && bus_addr == A_CTRL) ctrl_q <= bus_wdata;
      if (wr && bus_addr == A_DIVL) div_lo_q <= bus_wdata;
      if (wr && bus_addr == A_DIVH) div_hi_q <= bus_wdata;
      if (fault) ctrl_q[5:4] <= 2'b00;
      done_q <= done_set | (done_q & ~rd_stat);
      wcol_q <= collide  | (wcol_q & ~rd_stat);
      modf_q <= fault    | (modf_q & ~rd_stat);
      sck_sync <= {sck_sync[1:0], sck_i};
      brg_q <= (!busy_q || tick) ? divisor : brg_q - DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0; rx_sh <= '0; rx_data <= '0;
      bit_q <= '0; busy_q <= 1'b0; sck_q <= 1'b0;
    end else if (fault) begin
      busy_q <= 1'b0; sck_q <= 1'b0; bit_q <= '0;
    end else if (start) begin
      tx_sh <= bus_wdata; busy_q <= 1'b1; bit_q <= '0; sck_q <= 1'b0;
    end else if (tick) begin
      if (!sck_q) begin
        sck_q <= 1'b1;
        rx_sh <= {rx_sh[6:0], miso_i};
      end else begin
        sck_q <= 1'b0;
        tx_sh <= {tx_sh[6:0], 1'b0};
        bit_q <= bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          busy_q  <= 1'b0;
          rx_data <= rx_sh;
        end
      end
    end else if (slv_ld) begin
      tx_sh <= bus_wdata;
    end else if (!mst && ss_n_i) begin
      bit_q <= '0;
    end else if (s_rise) begin
      rx_sh <= {rx_sh[6:0], mosi_i};
      bit_q <= bit_q + 3'd1;
      if (bit_q == 3'd7) rx_data <= {rx_sh[6:0], mosi_i};
    end else if (s_fall) begin
      tx_sh <= {tx_sh[6:0], 1'b0};
    end
  end
endmodule

module spi_ctrl_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fault,
  input logic       collide,
  input logic       rd_stat,
  input logic       busy,
  input logic       sck,
  input logic [7:0] ctrl,
  input logic       done,
  input logic       wcol,
  input logic       modf,
  input logic       irq
);
  // R6
  modf_clears_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> modf && !ctrl[5] && !ctrl[4] && !busy);
  // R3
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
  // R5
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> wcol);
  // R7
  irq_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && ctrl[7] |-> irq);
  // R8
  read_clears_modf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat && !fault |=> !modf);
  // R4
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(fault) |-> done);
endmodule

bind spi_ctrl_core spi_ctrl_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fault(fault), .collide(collide), .rd_stat(rd_stat),
  .busy(busy_q), .sck(sck_q), .ctrl(ctrl_q), .done(done_q), .wcol(wcol_q),
  .modf(modf_q), .irq(irq)
);

// File: tb/test_spi_ctrl_core.sv
module test_spi_ctrl_core;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic irq, sck_o, mosi_o, miso_o, miso_i;
  logic sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;

  int checks = 0, errors = 0, cyc = 0;
  int rise_n = 0, last_rise = 0, period = 0, base_n = 0;
  logic [7:0] mosi_cap = '0, cur_pat = '0;
  bit done_flag = 1'b0;

  spi_ctrl_core i_spi_ctrl_core (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .sck_i(sck_i), .sck_o(sck_o), .mosi_i(mosi_i), .mosi_o(mosi_o),
    .miso_i(miso_i), .miso_o(miso_o), .ss_n_i(ss_n_i)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  always @(posedge sck_o) begin
    mosi_cap = {mosi_cap[6:0], mosi_o};
    period = cyc - last_rise;
    last_rise = cyc;
    rise_n++;
  end

  assign miso_i = ((rise_n - base_n) < 8) ? cur_pat[3'(7 - (rise_n - base_n))] : 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {divisor, tx byte, miso pattern}
  localparam logic [23:0] VEC [4] = '{
    {8'd2, 8'hA5, 8'h3C}, {8'd1, 8'h81, 8'h7E},
    {8'd3, 8'h00, 8'hFF}, {8'd5, 8'h5A, 8'hC3}};

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r, mis;
    idle(3); rst_n = 1; idle(2);
    // R1 reset state
    rd_reg(3'd0, r); check("R1 ctrl", r, 8'h00);
    rd_reg(3'd1, r); check("R1 status", r, 8'h00);
    rd_reg(3'd3, r); check("R1 div", r, 8'h00);
    rd_reg(3'd2, r); check("R1 data", r, 8'h00);
    check("R1 sck", sck_o, 0); check("R1 irq", irq, 0);

    // R10 readback
    wr_reg(3'd0, 8'h80); rd_reg(3'd0, r); check("R10 ctrl", r, 8'h80);
    wr_reg(3'd4, 8'h12); rd_reg(3'd4, r); check("R10 divh", r, 8'h12);
    wr_reg(3'd4, 8'h00);

    for (int i = 0; i < 4; i++) begin
      int d;
      d = int'(VEC[i][23:16]);
      wr_reg(3'd3, VEC[i][23:16]);
      wr_reg(3'd0, 8'h30);
      base_n = rise_n; cur_pat = VEC[i][7:0];
      wr_reg(3'd2, VEC[i][15:8]);
      idle(16 * d + 4);
      check("R3 rises", rise_n - base_n, 8);
      check("R3 mosi byte", mosi_cap, VEC[i][15:8]);
      check("R2 sck period", period, 2 * d);
      check("R3 sck idle", sck_o, 0);
      rd_reg(3'd2, r); check("R3 rx byte", r, VEC[i][7:0]);
      rd_reg(3'd1, r); check("R4 done", r, 8'h80);
      rd_reg(3'd1, r); check("R8 cleared", r, 8'h00);
    end

    // R5 collision
    wr_reg(3'd3, 8'd4);
    base_n = rise_n; cur_pat = 8'h00;
    wr_reg(3'd2, 8'hC3);
    idle(10);
    wr_reg(3'd2, 8'h11);
    idle(70);
    check("R5 original byte", mosi_cap, 8'hC3);
    check("R5 rises", rise_n - base_n, 8);
    rd_reg(3'd1, r); check("R5 wcol+done", r, 8'hA0);
    rd_reg(3'd1, r); check("R8 wcol cleared", r, 8'h00);

    // R7 completion interrupt
    wr_reg(3'd0, 8'hB0);
    base_n = rise_n;
    wr_reg(3'd2, 8'h01);
    idle(70);
    check("R7 irq on done", irq, 1);
    rd_reg(3'd1, r); idle(1);
    check("R7 irq drops", irq, 0);

    // R6 conflict during transfer, R7 irq
    base_n = rise_n;
    wr_reg(3'd2, 8'h55);
    idle(5);
    ss_n_i = 0; idle(1); ss_n_i = 1; idle(1);
    check("R7 irq on modf", irq, 1);
    check("R6 sck low", sck_o, 0);
    rd_reg(3'd0, r); check("R6 ctrl cleared", r, 8'h80);
    rd_reg(3'd1, r); check("R6 modf flag", r, 8'h10);
    idle(1); check("R8 irq after read", irq, 0);
    idle(40);
    rd_reg(3'd0, r); check("R6 not restored", r, 8'h80);

    // R8 same-cycle read and new conflict
    wr_reg(3'd0, 8'h30);
    ss_n_i = 0; idle(1); ss_n_i = 1;
    wr_reg(3'd0, 8'h30);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = 3'd1; ss_n_i = 0;
    #1 r = bus_rdata;
    @(negedge clk); bus_sel = 0; ss_n_i = 1;
    check("R8 read value", r, 8'h10);
    rd_reg(3'd1, r); check("R8 event wins", r, 8'h10);
    rd_reg(3'd0, r); check("R6 ctrl after", r, 8'h00);

    // R9 slave receive/transmit
    wr_reg(3'd0, 8'h20);
    wr_reg(3'd2, 8'h96);
    ss_n_i = 0;
    mis = '0;
    for (int k = 0; k < 8; k++) begin
      mosi_i = 1'(8'h4B >> (7 - k));
      idle(4);
      mis = {mis[6:0], miso_o};
      sck_i = 1; idle(4); sck_i = 0;
    end
    idle(4);
    check("R9 miso byte", mis, 8'h96);
    rd_reg(3'd1, r); check("R9 done", r, 8'h80);
    rd_reg(3'd2, r); check("R9 rx byte", r, 8'h4B);
    ss_n_i = 1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule